// File: doc/BRIEF.md
# Vertex Export Register Write Unit

This block holds the output register file of a small vertex processor: sixteen registers, each made of four 32-bit components named x, y, z and w. Data is carried as opaque words. Arithmetic happens elsewhere. On each instruction cycle with `wr_en_i` high, the block receives two results: one from the vector unit and one from the scalar unit. Each result arrives with its own 4-bit component mask. The block also receives the export fields of the instruction word and the four current address register values.

From the 5-bit export index field, the block forms an effective register number. When relative addressing is on, a chosen address register component is added to the field first. A single select bit decides whether the vector result or the scalar result is written. Only the masked components of the target register change, so a register can be filled over several instructions. The raw index value 31 turns export off for that instruction.

An out-of-range effective index raises `abort_o` in the same cycle, and nothing is written. A vector export whose local destination is unusable does the same. A combinational read port lets the downstream pipeline fetch any register. Register 0 is, by convention, where the transformed vertex position is placed.

Top module: `vx_export_file`

## Requirements
- R1: Reset (`rst_n` low) and a start-of-program pulse (`start_i` high at a clock edge) both set every component of every export register to zero.
- R2: With relative addressing off and `idx_field_i` in 0..15, a write goes to the register with that number. The result appears on the read port after the next rising clock edge.
- R3: An `idx_field_i` of 31 disables export for that instruction. No register changes and `abort_o` stays low. This holds whether or not relative addressing is on.
- R4: With relative addressing off, an `idx_field_i` from 16 to 30 raises `abort_o` in the same cycle, and no register changes.
- R5: With `sel_vec_i` = 1, the block writes `vec_data_i` under `vec_mask_i`. With `sel_vec_i` = 0, it writes `sca_data_i` under `sca_mask_i`. The mask of the unselected unit has no effect.
- R6: Mask bit 3 enables x (data bits 127:96), bit 2 enables y (95:64), bit 1 enables z (63:32) and bit 0 enables w (31:0). Components whose mask bit is clear keep their old value.
- R7: With `rel_en_i` = 1, the effective index is the signed 11-bit address component chosen by `areg_sel_i` plus the zero-extended field. Selector values map as 0 = x, 1 = y, 2 = z, 3 = w, packed in `areg_i` as x in bits 43:33, y in 32:22, z in 21:11 and w in 10:0. If the sum falls outside 0..15, `abort_o` rises and nothing is written.
- R8: A vector export (`sel_vec_i` = 1) whose `vec_dst_i` lies in 32..62 raises `abort_o` and writes nothing. Destinations 0..31 and 63 are accepted. A scalar export ignores `vec_dst_i`.
- R9: While `wr_en_i` is low, no register changes and `abort_o` stays low.
- R10: When `start_i` and a valid write fall in the same cycle, the clear wins, and every register reads zero afterwards.
- R11: `rd_data_o` always shows the current contents of the register selected by `rd_idx_i`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-program clear pulse |
| wr_en_i | input | 1 | Instruction valid this cycle |
| sel_vec_i | input | 1 | 1 = export vector result, 0 = export scalar result |
| idx_field_i | input | 5 | Export index field of the instruction |
| rel_en_i | input | 1 | Relative export addressing enable |
| areg_sel_i | input | 2 | Address component select (0 = x … 3 = w) |
| areg_i | input | 44 | Four signed 11-bit address registers, x in the top slice |
| vec_dst_i | input | 6 | Local destination of the vector unit |
| vec_data_i | input | 128 | Vector unit result, x in the top word |
| vec_mask_i | input | 4 | Vector component mask |
| sca_data_i | input | 128 | Scalar unit result, x in the top word |
| sca_mask_i | input | 4 | Scalar component mask |
| rd_idx_i | input | 4 | Read port register number |
| rd_data_o | output | 128 | Read port data |
| abort_o | output | 1 | Invalid export, program abort |

## Verification
The clear and a write can land on the same clock edge. The bench forces this by raising `start_i` during an instruction that would otherwise be valid. It then sweeps all sixteen registers through the read port and expects zero everywhere.

Abort detection and register update also meet in one cycle. The bench issues bad indices and bad destinations, both directly and through relative sums, and mixes them with valid writes to the same register numbers. For each one it checks `abort_o` before the edge. After the edge it confirms that the reference copy and the read port still agree on every component.

// File: rtl/vx_export_file.sv
module vx_export_file #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int AW   = 11,
  parameter int IW   = 5,
  parameter int DSTW = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      wr_en_i,
  input  logic                      sel_vec_i,
  input  logic [IW-1:0]             idx_field_i,
  input  logic                      rel_en_i,
  input  logic [1:0]                areg_sel_i,
  input  logic [4*AW-1:0]           areg_i,
  input  logic [DSTW-1:0]           vec_dst_i,
  input  logic [4*DW-1:0]           vec_data_i,
  input  logic [3:0]                vec_mask_i,
  input  logic [4*DW-1:0]           sca_data_i,
  input  logic [3:0]                sca_mask_i,
  input  logic [$clog2(NREG)-1:0]   rd_idx_i,
  output logic [4*DW-1:0]           rd_data_o,
  output logic                      abort_o
);
  localparam int RIW = $clog2(NREG);
  localparam int LW  = 4*DW;
  localparam int SW  = (AW > IW ? AW : IW) + 2;
  localparam logic [IW-1:0]         OFF_IDX = '1;
  localparam logic [DSTW-1:0]       DUMMY_DST = '1;
  localparam logic signed [SW-1:0]  NREG_S = SW'(NREG);

  logic [LW-1:0]          regs [NREG];
  logic signed [AW-1:0]   base;
  logic signed [SW-1:0]   base_x, fld_x, eff;
  logic                   off, idx_ok, dst_bad, we;
  logic [RIW-1:0]         widx;
  logic [LW-1:0]          wdata;
  logic [3:0]             wmask;

  always_comb begin
    case (areg_sel_i)
      2'd0:    base = areg_i[3*AW +: AW];
      2'd1:    base = areg_i[2*AW +: AW];
      2'd2:    base = areg_i[1*AW +: AW];
      default: base = areg_i[0 +: AW];
    endcase
  end

  assign base_x  = rel_en_i ? {{(SW-AW){base[AW-1]}}, base} : '0;
  assign fld_x   = {{(SW-IW){1'b0}}, idx_field_i};
  assign eff     = base_x + fld_x;
  assign off     = idx_field_i == OFF_IDX;
  assign idx_ok  = !eff[SW-1] && (eff < NREG_S);
  assign dst_bad = sel_vec_i && vec_dst_i[DSTW-1] && (vec_dst_i != DUMMY_DST);
  assign abort_o = wr_en_i && !off && (!idx_ok || dst_bad);
  assign we      = wr_en_i && !off && idx_ok && !dst_bad;
  assign widx    = eff[RIW-1:0];
  assign wdata   = sel_vec_i ? vec_data_i : sca_data_i;
  assign wmask   = sel_vec_i ? vec_mask_i : sca_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (start_i) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (we) begin
      for (int c = 0; c < 4; c++)
        if (wmask[c]) regs[widx][c*DW +: DW] <= wdata[c*DW +: DW];
    end
  end

  assign rd_data_o = regs[rd_idx_i];

  logic [NREG*LW-1:0] flat;
  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign flat[k*LW +: LW] = regs[k];
  end

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (flat == '0));

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_field_i == OFF_IDX) |-> !abort_o);

  assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_field_i == OFF_IDX && !start_i) |=> $stable(flat));

  assert_abort_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && !start_i) |=> $stable(flat));

  assert_direct_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rel_en_i && idx_field_i >= IW'(NREG) && idx_field_i != OFF_IDX) |-> abort_o);

  assert_bad_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_vec_i && idx_field_i != OFF_IDX &&
     vec_dst_i >= DSTW'(32) && vec_dst_i != DUMMY_DST) |-> abort_o);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |-> !abort_o);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !start_i) |=> $stable(flat));

  for (genvar c = 0; c < 4; c++) begin : g_comp
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(wr_en_i && (sel_vec_i ? vec_mask_i[c] : sca_mask_i[c])))
        |=> $stable(regs[k][c*DW +: DW]));
    end
  end
endmodule

// File: tb/sim_vx_export_file.sv
`timescale 1ns/100ps
module sim_vx_export_file;
  logic clk = 0, rst_n = 0, start = 0, wr = 0, sv = 0, rel = 0;
  logic [4:0] fld = 0;
  logic [1:0] asel = 0;
  logic [43:0] areg = 0;
  logic [5:0] dst = 0;
  logic [127:0] vd = 0, sd = 0, rd;
  logic [3:0] vm = 0, sm = 0, ridx = 0;
  logic ab;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [127:0] m [16];

  always #2.5 clk = ~clk;

  vx_export_file u0 (.clk(clk), .rst_n(rst_n), .start_i(start), .wr_en_i(wr),
    .sel_vec_i(sv), .idx_field_i(fld), .rel_en_i(rel), .areg_sel_i(asel),
    .areg_i(areg), .vec_dst_i(dst), .vec_data_i(vd), .vec_mask_i(vm),
    .sca_data_i(sd), .sca_mask_i(sm), .rd_idx_i(ridx), .rd_data_o(rd), .abort_o(ab));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_idx();
    int a;
    a = 0;
    if (rel) a = int'($signed(areg[(3-asel)*11 +: 11]));
    return a + int'(fld);
  endfunction

  function automatic bit exp_abort();
    int e;
    bit bad_dst;
    e = eff_idx();
    bad_dst = sv && dst >= 32 && dst != 63;
    return wr && fld != 31 && (e < 0 || e > 15 || bad_dst);
  endfunction

  task automatic sweep(input string tag);
    for (int k = 0; k < 16; k++) begin
      ridx = 4'(k);
      #0.1;
      chk(rd === m[k], tag, rd, m[k]);
    end
  endtask

  task automatic instr(input string tag);
    bit ea;
    int e;
    #0.5;
    ea = exp_abort();
    e = eff_idx();
    chk(ab === ea, {tag, " abort R4 R7 R8 R9"}, 128'(ab), 128'(ea));
    @(posedge clk);
    if (start) for (int k = 0; k < 16; k++) m[k] = '0;
    else if (wr && fld != 31 && !ea)
      for (int c = 0; c < 4; c++)
        if ((sv ? vm[c] : sm[c])) m[e][c*32 +: 32] = sv ? vd[c*32 +: 32] : sd[c*32 +: 32];
    @(negedge clk);
    wr = 0; start = 0;
    sweep({tag, " R11 contents"});
  endtask

  task automatic setw(input bit s, input logic [4:0] f, input bit r, input logic [3:0] vmask, input logic [3:0] smask);
    wr = 1; sv = s; fld = f; rel = r; vm = vmask; sm = smask;
    vd = {$urandom, $urandom, $urandom, $urandom};
    sd = {$urandom, $urandom, $urandom, $urandom};
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    for (int k = 0; k < 16; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sweep("R1 reset clear");

    dst = 6'd5;
    setw(1, 5'd3, 0, 4'hF, 4'h0); instr("R2 R5 direct vector full");
    setw(0, 5'd3, 0, 4'hF, 4'b0101); instr("R5 R6 scalar partial");
    for (int c = 0; c < 4; c++) begin
      setw(1, 5'd0, 0, 4'(1 << c), 4'hF); instr("R6 single component");
    end
    setw(1, 5'd31, 0, 4'hF, 4'hF); instr("R3 export off");
    setw(1, 5'd31, 1, 4'hF, 4'hF); areg = {11'h7FF, 33'd0}; instr("R3 export off relative");
    setw(1, 5'd20, 0, 4'hF, 4'hF); instr("R4 invalid field");
    setw(1, 5'd30, 0, 4'hF, 4'hF); instr("R4 invalid field 30");
    areg = {11'd0, 11'd7, 11'h7FD, 11'd20};
    asel = 2'd2; setw(1, 5'd5, 1, 4'hF, 4'h0); instr("R7 relative negative offset");
    asel = 2'd2; setw(1, 5'd1, 1, 4'hF, 4'h0); instr("R7 relative below zero");
    asel = 2'd1; setw(1, 5'd8, 1, 4'hF, 4'h0); instr("R7 relative top register");
    asel = 2'd1; setw(1, 5'd9, 1, 4'hF, 4'h0); instr("R7 relative above range");
    asel = 2'd3; setw(1, 5'd0, 1, 4'hF, 4'h0); instr("R7 relative large");
    dst = 6'd40; setw(1, 5'd2, 0, 4'hF, 4'h0); instr("R8 bad vector dest");
    dst = 6'd62; setw(1, 5'd2, 0, 4'hF, 4'h0); instr("R8 bad vector dest 62");
    dst = 6'd63; setw(1, 5'd2, 0, 4'hF, 4'h0); instr("R8 dummy dest");
    dst = 6'd40; setw(0, 5'd4, 0, 4'h0, 4'hF); instr("R8 scalar ignores dest");
    dst = 6'd31; setw(1, 5'd6, 0, 4'hF, 4'h0); wr = 0; instr("R9 idle");
    setw(1, 5'd7, 0, 4'hF, 4'h0); start = 1; instr("R10 clear beats write");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] f;
      f = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 16);
      setw(1'($urandom), f, ($urandom % 3 == 0), 4'($urandom), 4'($urandom));
      wr = ($urandom % 8 != 0);
      dst = ($urandom % 5 == 0) ? 6'($urandom) : 6'($urandom % 32);
      asel = 2'($urandom);
      for (int c = 0; c < 4; c++)
        areg[c*11 +: 11] = ($urandom % 10 == 0) ? 11'($urandom) : 11'(int'($urandom % 31) - 15);
      start = ($urandom % 50 == 0);
      instr("R2 R5 R6 R7 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule